// File: doc/BRIEF.md
# Parallel port interrupt controller

This block gives a host four byte-wide digital ports and one configurable interrupt. It sits behind a plain chip-select bus with read and write strobes, and eight byte offsets. Offsets 0 to 3 reach ports A to D. Offset 5 is the control and status byte. The other offsets read as zero.

Each port has an output latch and an output-enable flag. The flags are clear after reset, so every pin starts as an input. The first write to a port sets its flag. A port read always returns the pin levels.

Bit 0 of port A is the only interrupt source. It passes through a two-flop synchronizer. It then drives one of four trigger conditions: low level, high level, falling edge or rising edge. A pending flag records a trigger whether or not interrupts are enabled. A read of the control byte clears the flag, unless the trigger condition is present in that same cycle. The request output is raised only while the enable bit and the pending flag are both set.

Top module: `pario_irq_ctrl`

## Requirements
- R1: A write to offset p (0..3) stores the write data into the output latch of port p. A read of offset p returns the pin levels of port p on `rdata_o` one clock edge after the read strobe. `rdata_o` holds its value while no read is made.
- R2: While reset is held, all output latches and all output-enable flags are zero, `rdata_o` is zero, the enable bit is 0, the mode is 00 and `irq_o` is low.
- R3: A write to port p sets `pin_oe_o[p]`. The flag then stays set until reset.
- R4: Reads of offsets 4, 6 and 7 return 0x00. Writes to those offsets change no latch, no output-enable flag and no control field.
- R5: A read of offset 5 returns the enable bit in bit 7, the pending flag in bit 6 and the mode in bits 1:0. Bits 5:2 read as zero.
- R6: Mode 00 is low-level and mode 01 is high-level. While the synchronized source is at the active level, the pending flag is set. A pin change becomes visible in the flag three clock edges later.
- R7: Mode 10 is falling-edge and mode 11 is rising-edge. Each such transition of the synchronized source sets the pending flag. A transition in the opposite direction does not set it.
- R8: A read of offset 5 clears the pending flag, unless the trigger condition holds in that same cycle. In a level mode, the flag therefore stays set until the source has left its active level. In an edge mode, a new edge coinciding with the read re-sets the flag.
- R9: `irq_o` equals the enable bit ANDed with the pending flag. The flag keeps latching while the enable bit is 0.
- R10: A write to offset 5 loads the enable bit from data bit 7 and the mode from data bits 1:0. It leaves the pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, qualified by cs_i |
| wr_i | input | 1 | Write strobe, qualified by cs_i |
| addr_i | input | 3 | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 32 | Pin levels, port A in bits 7:0 through port D in bits 31:24 |
| pin_o | output | 32 | Output latches, same packing as pin_i |
| pin_oe_o | output | 4 | Per-port output enable, bit p for port p |
| irq_o | output | 1 | Interrupt request |

## Verification
Three latencies matter here:
- Read data and port writes show up one rising edge after the strobe cycle.
- Control writes take effect at the same edge.
- A change on the source pin reaches the pending flag and `irq_o` three rising edges after it is driven: two synchronizer stages, then the latch.

The bench drives inputs and samples outputs on the falling edge. After every rising edge it advances a behavioural reference model by exactly one step, so each of these delays is matched edge for edge. Clearing reads are swept across the cycles around a source edge. This places the read before, on and after the edge that re-sets the flag.

// File: rtl/pario_pkg.sv
package pario_pkg;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'b00,
      TRIG_HIGH = 2'b01,
      TRIG_FALL = 2'b10,
      TRIG_RISE = 2'b11
   } trig_mode_e;

   localparam int unsigned MAP_PORTS_MAX = 4;
   localparam int unsigned OFS_CTRL      = 5;
   localparam int unsigned CTRL_EN_BIT   = 7;
   localparam int unsigned CTRL_ST_BIT   = 6;
   localparam int unsigned MAP_ADDR_W    = 3;

endpackage

// File: rtl/pario_sync.sv
module pario_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("pario_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= RESET_VAL;
         else        chain_q <= d_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
         else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pario_port_bank.sv
module pario_port_bank #(
   parameter int unsigned NPORTS = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned BUS_W = NPORTS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] wr_sel_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [BUS_W-1:0]  pin_o,
   output logic [NPORTS-1:0] oe_o
);

   if (NPORTS < 1) begin : g_bad_nports
      $error("pario_port_bank: NPORTS must be at least 1");
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic [DATA_W-1:0] latch_q;
      logic              oe_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            latch_q <= '0;
            oe_q    <= 1'b0;
         end else if (wr_sel_i[p]) begin
            latch_q <= wdata_i;
            oe_q    <= 1'b1;
         end
      end

      assign pin_o[p*DATA_W +: DATA_W] = latch_q;
      assign oe_o[p]                   = oe_q;

      // R3: once a port turns to output it stays so until reset
      p_oe_sticky_r3 : assert property (@(posedge clk) disable iff (!rst_n)
         oe_q |=> oe_q);
   end

   // R1: the address decode selects at most one port per cycle
   p_wr_onehot_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel_i));

endmodule

// File: rtl/pario_irq_unit.sv
module pario_irq_unit
   import pario_pkg::*;
#(
   parameter bit REG_IRQ_OUT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       src_i,
   input  logic       ctl_we_i,
   input  logic       ctl_en_i,
   input  logic [1:0] ctl_mode_i,
   input  logic       clr_req_i,
   output logic       en_o,
   output logic [1:0] mode_o,
   output logic       status_o,
   output logic       irq_o
);

   logic       prev_q;
   logic       en_q;
   trig_mode_e mode_q;
   logic       status_q;
   logic       hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= src_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= TRIG_LOW;
      end else if (ctl_we_i) begin
         en_q   <= ctl_en_i;
         mode_q <= trig_mode_e'(ctl_mode_i);
      end
   end

   always_comb begin
      unique case (mode_q)
         TRIG_LOW:  hit = ~src_i;
         TRIG_HIGH: hit =  src_i;
         TRIG_FALL: hit =  prev_q & ~src_i;
         TRIG_RISE: hit = ~prev_q &  src_i;
      endcase
   end

   // a trigger in the clearing cycle wins over the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= 1'b0;
      else        status_q <= hit | (status_q & ~clr_req_i);
   end

   if (REG_IRQ_OUT) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= en_q & status_q;
      end
      assign irq_o = irq_q;

      // R9: a disabled controller raises no request on the next edge
      p_irq_off_r9 : assert property (@(posedge clk) disable iff (!rst_n)
         !en_q |=> !irq_o);
   end else begin : g_irq_comb
      assign irq_o = en_q & status_q;

      // R9: a disabled controller raises no request
      p_irq_off_r9 : assert property (@(posedge clk) disable iff (!rst_n)
         !en_q |-> !irq_o);
   end

   assign en_o     = en_q;
   assign mode_o   = mode_q;
   assign status_o = status_q;

   // R6: active level latches the flag on the next edge
   p_level_set_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == TRIG_HIGH && src_i) || (mode_q == TRIG_LOW && !src_i))
      |=> status_q);

   // R7: rising edge in rising mode latches the flag
   p_rise_set_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == TRIG_RISE && !prev_q && src_i) |=> status_q);

   // R7: falling edge in falling mode latches the flag
   p_fall_set_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == TRIG_FALL && prev_q && !src_i) |=> status_q);

   // R8: only a clearing read can drop the flag
   p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_req_i) |=> status_q);

   // R8: in an edge mode with a steady source, a clearing read empties the flag
   p_edge_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req_i && mode_q[1] && (src_i == prev_q)) |=> !status_q);

endmodule

// File: rtl/pario_irq_ctrl.sv
module pario_irq_ctrl
   import pario_pkg::*;
#(
   parameter int unsigned NPORTS      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IRQ_BIT     = 0,
   parameter bit          REG_IRQ_OUT = 1'b0,
   localparam int unsigned BUS_W      = NPORTS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [BUS_W-1:0]  pin_i,
   output logic [BUS_W-1:0]  pin_o,
   output logic [NPORTS-1:0] pin_oe_o,
   output logic              irq_o
);

   if (DATA_W != 8) begin : g_bad_width
      $error("pario_irq_ctrl: control byte layout needs DATA_W == 8");
   end
   if (ADDR_W != MAP_ADDR_W) begin : g_bad_addr
      $error("pario_irq_ctrl: ADDR_W must match the 8-offset map");
   end
   if (NPORTS < 1 || NPORTS > MAP_PORTS_MAX) begin : g_bad_ports
      $error("pario_irq_ctrl: NPORTS must be 1..4");
   end
   if (IRQ_BIT >= DATA_W) begin : g_bad_bit
      $error("pario_irq_ctrl: IRQ_BIT must lie in port A");
   end

   logic              rd_hit;
   logic              wr_hit;
   logic              ctl_sel;
   logic [NPORTS-1:0] port_wr;
   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] rdata_q;
   logic              src_sync;
   logic              en;
   logic [1:0]        mode;
   logic              status;

   assign rd_hit  = cs_i & rd_i;
   assign wr_hit  = cs_i & wr_i;
   assign ctl_sel = (addr_i == ADDR_W'(OFS_CTRL));

   for (genvar p = 0; p < NPORTS; p++) begin : g_dec
      assign port_wr[p] = wr_hit & (addr_i == ADDR_W'(p));
   end

   pario_port_bank #(
      .NPORTS (NPORTS),
      .DATA_W (DATA_W)
   ) u_ports (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel_i (port_wr),
      .wdata_i  (wdata_i),
      .pin_o    (pin_o),
      .oe_o     (pin_oe_o)
   );

   pario_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b0)
   ) u_src_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i[IRQ_BIT]),
      .q_o   (src_sync)
   );

   pario_irq_unit #(
      .REG_IRQ_OUT (REG_IRQ_OUT)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_sync),
      .ctl_we_i   (wr_hit & ctl_sel),
      .ctl_en_i   (wdata_i[CTRL_EN_BIT]),
      .ctl_mode_i (wdata_i[1:0]),
      .clr_req_i  (rd_hit & ctl_sel),
      .en_o       (en),
      .mode_o     (mode),
      .status_o   (status),
      .irq_o      (irq_o)
   );

   always_comb begin
      rd_val = '0;
      for (int p = 0; p < int'(NPORTS); p++) begin
         if (addr_i == ADDR_W'(p)) rd_val = pin_i[p*DATA_W +: DATA_W];
      end
      if (ctl_sel) begin
         rd_val                 = '0;
         rd_val[CTRL_EN_BIT]    = en;
         rd_val[CTRL_ST_BIT]    = status;
         rd_val[1:0]            = mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_hit) rdata_q <= rd_val;
   end

   assign rdata_o = rdata_q;

   // R4: unused offsets read as zero
   p_rsv_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && (addr_i == 3'd4 || addr_i == 3'd6 || addr_i == 3'd7))
      |=> (rdata_o == '0));

   // R5: the unused middle bits of the control byte read as zero
   p_ctl_pad_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && ctl_sel) |=> (rdata_o[5:2] == 4'b0000));

   // R10: a control write never clears the pending flag
   p_wr_keeps_status_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && ctl_sel && !rd_hit && status) |=> status);

   // R1: read data holds between reads
   p_rdata_hold_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> $stable(rdata_o));

endmodule

// File: tb/tb_pario_irq_ctrl.sv
module tb_pario_irq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [7:0]  wd = '0;
   logic [31:0] pins = '0;
   logic [7:0]  rdata;
   logic [31:0] pout;
   logic [3:0]  poe;
   logic        irq;

   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   string ph     = "R2";

   // reference model state
   bit       m_s1, m_s2, m_prev, m_stat, m_en;
   bit [1:0] m_mode;
   bit [7:0] m_lat [4];
   bit [3:0] m_oe;
   bit [7:0] m_rd;

   pario_irq_ctrl dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_i     (cs),
      .rd_i     (rd),
      .wr_i     (wr),
      .addr_i   (addr),
      .wdata_i  (wd),
      .rdata_o  (rdata),
      .pin_i    (pins),
      .pin_o    (pout),
      .pin_oe_o (poe),
      .irq_o    (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, WATCHDOG);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      bit       hit;
      bit       rd5;
      bit [7:0] lat_flat;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0; m_en = 0; m_mode = 0;
         m_oe = 0; m_rd = 0;
         foreach (m_lat[i]) m_lat[i] = 0;
         return;
      end
      case (m_mode)
         2'd0: hit = !m_s2;
         2'd1: hit = m_s2;
         2'd2: hit = m_prev && !m_s2;
         default: hit = !m_prev && m_s2;
      endcase
      rd5 = cs && rd && addr == 3'd5;
      if (cs && rd) begin
         if (addr < 3'd4)       m_rd = pins[addr*8 +: 8];
         else if (addr == 3'd5) m_rd = {m_en, m_stat, 4'b0000, m_mode};
         else                   m_rd = 8'h00;
      end
      if (cs && wr) begin
         if (addr < 3'd4) begin
            m_lat[addr] = wd;
            m_oe[addr]  = 1'b1;
         end else if (addr == 3'd5) begin
            m_en   = wd[7];
            m_mode = wd[1:0];
         end
      end
      m_stat = hit || (m_stat && !rd5);
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pins[0];
      lat_flat = 0;
   endtask

   task automatic compare();
      check(ph, "rdata", rdata, m_rd);
      check(ph, "irq", irq, m_en && m_stat);
      check(ph, "pin_oe", poe, m_oe);
      check(ph, "pin_o", pout, {m_lat[3], m_lat[2], m_lat[1], m_lat[0]});
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      cs = 1; wr = 1; addr = a; wd = d;
      tick();
      cs = 0; wr = 0;
   endtask

   task automatic bus_rd(input logic [2:0] a);
      cs = 1; rd = 1; addr = a;
      tick();
      cs = 0; rd = 0;
   endtask

   initial begin
      // R2: reset state held for several edges
      ph = "R2";
      idle(3);
      check("R2", "irq in reset", irq, 0);
      check("R2", "oe in reset", poe, 0);
      check("R2", "rdata in reset", rdata, 0);
      rst_n = 1'b1;
      idle(2);

      // R1: port writes and reads
      ph = "R1";
      bus_wr(3'd1, 8'hA5);
      bus_wr(3'd3, 8'h3C);
      pins = 32'h9A_7E_C3_10;
      bus_rd(3'd0);
      check("R1", "port A read", rdata, 8'h10);
      bus_rd(3'd2);
      check("R1", "port C read", rdata, 8'h7E);
      idle(2);
      check("R1", "read data holds", rdata, 8'h7E);
      bus_rd(3'd3);
      bus_rd(3'd1);

      // R3: output enable set by writes and sticky
      ph = "R3";
      bus_wr(3'd0, 8'h5A);
      bus_wr(3'd2, 8'h81);
      check("R3", "all oe set", poe, 4'hF);
      bus_wr(3'd2, 8'h00);
      check("R3", "oe stays", poe, 4'hF);

      // R4: reserved offsets
      ph = "R4";
      bus_wr(3'd4, 8'hFF);
      bus_wr(3'd6, 8'hFF);
      bus_wr(3'd7, 8'h83);
      bus_rd(3'd4); check("R4", "offset 4", rdata, 0);
      bus_rd(3'd6); check("R4", "offset 6", rdata, 0);
      bus_rd(3'd7); check("R4", "offset 7", rdata, 0);
      check("R4", "no enable from reserved write", irq, 0);

      // R5 / R10: control format and status immunity
      ph = "R5";
      pins[0] = 1'b1;
      idle(4);
      bus_rd(3'd5);  // clears flag latched in low mode
      bus_wr(3'd5, 8'h7D);  // bit7=0, mode 01
      idle(4);
      bus_rd(3'd5);
      check("R5", "ctrl byte", rdata, 8'h41);
      ph = "R10";
      bus_wr(3'd5, 8'hBD);  // enable, high mode, status bit written 0
      check("R10", "status kept after write", irq, 1);
      bus_wr(3'd5, 8'h01);
      bus_wr(3'd5, 8'h81);
      check("R10", "irq back with status kept", irq, 1);

      // R6: level modes, flag sticks while level active
      ph = "R6";
      bus_rd(3'd5);
      bus_rd(3'd5);
      check("R6", "high level keeps flag", rdata[6], 1);
      pins[0] = 1'b0;
      idle(3);
      bus_rd(3'd5);
      bus_rd(3'd5);
      check("R6", "flag cleared after level left", rdata[6], 0);
      bus_wr(3'd5, 8'h80);  // low level
      idle(2);
      check("R6", "low level irq", irq, 1);
      pins[0] = 1'b1;
      idle(3);
      bus_rd(3'd5);
      idle(1);
      check("R6", "low level cleared", irq, 0);

      // R7: edge modes
      ph = "R7";
      bus_wr(3'd5, 8'h82);  // falling
      bus_rd(3'd5);
      pins[0] = 1'b0;
      idle(2);
      check("R7", "before sync delay", irq, 0);
      idle(1);
      check("R7", "falling edge", irq, 1);
      bus_rd(3'd5);
      pins[0] = 1'b1;
      idle(4);
      check("R7", "rise ignored in falling mode", irq, 0);
      bus_wr(3'd5, 8'h83);  // rising
      pins[0] = 1'b0;
      idle(4);
      pins[0] = 1'b1;
      idle(4);
      check("R7", "rising edge", irq, 1);

      // R8: clearing read swept around a new edge
      ph = "R8";
      for (int d = 0; d < 5; d++) begin
         pins[0] = 1'b0;
         idle(3);
         bus_rd(3'd5);
         pins[0] = 1'b1;
         idle(d);
         bus_rd(3'd5);
         idle(4);
         bus_rd(3'd5);
      end
      check("R8", "final clear", irq, 0);

      // R9: latching while disabled
      ph = "R9";
      bus_wr(3'd5, 8'h03);
      pins[0] = 1'b0;
      idle(3);
      pins[0] = 1'b1;
      idle(4);
      check("R9", "disabled holds irq low", irq, 0);
      bus_wr(3'd5, 8'h83);
      check("R9", "enable exposes latched flag", irq, 1);
      bus_rd(3'd5);
      idle(2);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule